// File: doc/BRIEF.md
# Resistive Panel Switch and Pen-Detect Controller

This block turns a small configuration word into the switch enables for a five-wire resistive touch panel. The word carries a 3-bit channel code, a reference-mode bit and a 2-bit power-down code. Four phase strobes tell the block which step of a conversion is running: idle, acquire, convert or power-down. From the configuration and the phase, the block drives a supply and/or ground enable at each of the four panel corners. It also drives the analog input mux select, the path that routes the pen-sense node to the wiper, a registered active-low pen-interrupt output, and a request that forces the serial data line to a fixed level while pen polling runs.

The switches, the panel and the converter exist only as enables here. The panel's touch state arrives as a digital input, `pen_touch`, and the serial protocol lives elsewhere. Every output is a register. A configuration update or a phase strobe that is sampled on a rising edge shows up on the outputs right after that same edge.

Top module: `panel_switch_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every corner enable, `pen_path`, `mux_sel`, `dout_ovr` and `dout_val` are cleared and `pen_irq_n` is 1. The configuration resets to channel 000, single-ended, power-down code 00, and the phase resets to idle.
- R2: Channel code 001 is the vertical measurement. When the drivers are active it enables `drv_ul_sup`, `drv_ur_sup`, `drv_ll_gnd` and `drv_lr_gnd`, and `mux_sel` is 01 (wiper).
- R3: Channel code 101 is the horizontal measurement. When the drivers are active it enables `drv_ul_sup`, `drv_ll_sup`, `drv_ur_gnd` and `drv_lr_gnd`, and `mux_sel` is 01. No corner ever has its supply and ground enables on together.
- R4: Channel code 010 selects the auxiliary input (`mux_sel` 10). Channel code 110 (pen polling) and the unused codes select nothing (`mux_sel` 00). None of these codes turns on a measurement driver in any phase.
- R5: With `cfg_single` = 1, the measurement drivers are on only during the acquire phase and turn off on the edge that enters convert.
- R6: With `cfg_single` = 0 (ratiometric), the measurement drivers stay on through both the acquire and the convert phases.
- R7: With power-down code 00, in the idle and power-down phases, `drv_lr_gnd` and `pen_path` are 1 and `pen_irq_n` equals the inverse of `pen_touch`.
- R8: With power-down code 01 or the reserved code 10, `pen_path` and `drv_lr_gnd` stay 0 outside a measurement, and `pen_irq_n` stays 1 even while the panel is touched.
- R9: With power-down code 11 and a measurement channel, the drivers stay on after the convert phase ends. They remain on until a configuration write changes any field, `csn` is sampled high, or a new acquire begins. A write of identical values does not release them.
- R10: `pen_path` is never 1 while any supply enable is on, so the pen node is detached during measurements.
- R11: With channel 110, power-down code 00 and `csn` low, `dout_ovr` is 1 and `dout_val` equals `pen_touch` (all ones touched, all zeros untouched). Otherwise both are 0.
- R12: When several phase strobes arrive in the same cycle, convert wins over acquire, acquire over power-down, and power-down over idle. With no strobe, the phase holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_chan | input | 3 | Channel code |
| cfg_single | input | 1 | 1 = single-ended reference, 0 = ratiometric |
| cfg_pd | input | 2 | Power-down code |
| stb_idle | input | 1 | Enter idle phase |
| stb_acq | input | 1 | Enter acquire phase |
| stb_conv | input | 1 | Enter convert phase |
| stb_pdn | input | 1 | Enter power-down phase |
| csn | input | 1 | Chip select, active low |
| pen_touch | input | 1 | Panel touched (sensed contact) |
| drv_ul_sup | output | 1 | Upper-left corner to supply |
| drv_ur_sup | output | 1 | Upper-right corner to supply |
| drv_ur_gnd | output | 1 | Upper-right corner to ground |
| drv_ll_sup | output | 1 | Lower-left corner to supply |
| drv_ll_gnd | output | 1 | Lower-left corner to ground |
| drv_lr_gnd | output | 1 | Lower-right corner to ground |
| pen_path | output | 1 | Pen-sense node connected to wiper |
| pen_irq_n | output | 1 | Pen interrupt, active low |
| mux_sel | output | 2 | Converter input: 00 none, 01 wiper, 10 auxiliary |
| dout_ovr | output | 1 | Force serial data line |
| dout_val | output | 1 | Forced serial data level |

## Verification
The vertical and horizontal codes are each run through a full acquire, convert and idle sequence in both reference modes. This shows that the corner pattern depends only on the channel, and that the driver on-time depends only on the reference bit. Power-down codes 00, 01, 10 and 11 are each tried with the panel touched and untouched, in the idle and power-down phases. This separates true pen sensing from a stuck interrupt. The hold of code 11 is released in turn by a changed write, by chip select and by a new acquire, and an identical write is shown not to release it. Simultaneous strobes and the polling override with chip select toggled cover the priority and data-forcing paths.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int CHAN_W = 3;
  localparam int PD_W   = 2;
  localparam int MUX_W  = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_CONV = 2'd2,
    PH_PDN  = 2'd3
  } phase_e;

  typedef struct packed {
    logic ul_sup;
    logic ur_sup;
    logic ur_gnd;
    logic ll_sup;
    logic ll_gnd;
    logic lr_gnd;
  } corner_t;

  localparam logic [CHAN_W-1:0] CH_VERT = 3'b001;
  localparam logic [CHAN_W-1:0] CH_HORZ = 3'b101;
  localparam logic [CHAN_W-1:0] CH_AUX  = 3'b010;
  localparam logic [CHAN_W-1:0] CH_POLL = 3'b110;

  localparam logic [PD_W-1:0] PD_SENSE  = 2'b00;
  localparam logic [PD_W-1:0] PD_ALWAYS = 2'b11;

  localparam logic [MUX_W-1:0] MUX_NONE  = 2'd0;
  localparam logic [MUX_W-1:0] MUX_WIPER = 2'd1;
  localparam logic [MUX_W-1:0] MUX_AUX   = 2'd2;

  function automatic logic is_meas(input logic [CHAN_W-1:0] ch);
    return (ch == CH_VERT) || (ch == CH_HORZ);
  endfunction
endpackage

// File: rtl/psc_phase_track.sv
module psc_phase_track
  import psc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   stb_idle,
  input  logic   stb_acq,
  input  logic   stb_conv,
  input  logic   stb_pdn,
  input  logic   csn,
  input  logic   cfg_chg,
  input  logic   keep_on_n,
  output phase_e phase_n,
  output logic   hold_n
);
  phase_e phase_q;
  logic   hold_q;

  // priority: convert > acquire > power-down > idle (R12)
  always_comb begin
    if (stb_conv)      phase_n = PH_CONV;
    else if (stb_acq)  phase_n = PH_ACQ;
    else if (stb_pdn)  phase_n = PH_PDN;
    else if (stb_idle) phase_n = PH_IDLE;
    else               phase_n = phase_q;
  end

  // driver hold after a conversion in always-powered mode (R9)
  always_comb begin
    if (csn || cfg_chg || phase_n == PH_ACQ)
      hold_n = 1'b0;
    else if (phase_q == PH_CONV && phase_n != PH_CONV && keep_on_n)
      hold_n = 1'b1;
    else
      hold_n = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      hold_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      hold_q  <= hold_n;
    end
  end
endmodule

// File: rtl/psc_switch_decode.sv
module psc_switch_decode
  import psc_pkg::*;
(
  input  logic [CHAN_W-1:0] chan,
  input  logic              single,
  input  logic [PD_W-1:0]   pd,
  input  phase_e            phase,
  input  logic              hold,
  input  logic              csn,
  input  logic              touch,
  output corner_t           corner,
  output logic              sense,
  output logic              irq_n,
  output logic [MUX_W-1:0]  mux,
  output logic              ovr,
  output logic              oval
);
  logic meas;
  logic active;

  assign meas   = is_meas(chan);
  assign active = meas && ((phase == PH_ACQ) ||
                           (phase == PH_CONV && !single) || hold);
  assign sense  = (pd == PD_SENSE) && !active &&
                  ((phase == PH_IDLE) || (phase == PH_PDN));

  always_comb begin
    corner = '0;
    if (active) begin
      corner.ul_sup = 1'b1;
      corner.lr_gnd = 1'b1;
      if (chan == CH_VERT) begin
        corner.ur_sup = 1'b1;
        corner.ll_gnd = 1'b1;
      end else begin
        corner.ur_gnd = 1'b1;
        corner.ll_sup = 1'b1;
      end
    end
    if (sense) corner.lr_gnd = 1'b1;
  end

  always_comb begin
    if (meas)                mux = MUX_WIPER;
    else if (chan == CH_AUX) mux = MUX_AUX;
    else                     mux = MUX_NONE;
  end

  assign irq_n = !(sense && touch);
  assign ovr   = (chan == CH_POLL) && (pd == PD_SENSE) && !csn;
  assign oval  = ovr && touch;
endmodule

// File: rtl/panel_switch_ctrl.sv
module panel_switch_ctrl
  import psc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic              cfg_single,
  input  logic [PD_W-1:0]   cfg_pd,
  input  logic              stb_idle,
  input  logic              stb_acq,
  input  logic              stb_conv,
  input  logic              stb_pdn,
  input  logic              csn,
  input  logic              pen_touch,
  output logic              drv_ul_sup,
  output logic              drv_ur_sup,
  output logic              drv_ur_gnd,
  output logic              drv_ll_sup,
  output logic              drv_ll_gnd,
  output logic              drv_lr_gnd,
  output logic              pen_path,
  output logic              pen_irq_n,
  output logic [MUX_W-1:0]  mux_sel,
  output logic              dout_ovr,
  output logic              dout_val
);
  logic [CHAN_W-1:0] chan_q, chan_n;
  logic              single_q, single_n;
  logic [PD_W-1:0]   pd_q, pd_n;
  logic              cfg_chg;
  phase_e            phase_n;
  logic              hold_n;
  corner_t           corner_d, corner_q;
  logic              sense_d, irq_n_d, ovr_d, oval_d;
  logic [MUX_W-1:0]  mux_d;

  assign chan_n   = cfg_valid ? cfg_chan   : chan_q;
  assign single_n = cfg_valid ? cfg_single : single_q;
  assign pd_n     = cfg_valid ? cfg_pd     : pd_q;
  assign cfg_chg  = cfg_valid && ((cfg_chan != chan_q) ||
                    (cfg_single != single_q) || (cfg_pd != pd_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q   <= '0;
      single_q <= 1'b1;
      pd_q     <= PD_SENSE;
    end else begin
      chan_q   <= chan_n;
      single_q <= single_n;
      pd_q     <= pd_n;
    end
  end

  psc_phase_track u_phase (
    .clk      (clk),
    .rst      (rst),
    .stb_idle (stb_idle),
    .stb_acq  (stb_acq),
    .stb_conv (stb_conv),
    .stb_pdn  (stb_pdn),
    .csn      (csn),
    .cfg_chg  (cfg_chg),
    .keep_on_n(is_meas(chan_n) && (pd_n == PD_ALWAYS)),
    .phase_n  (phase_n),
    .hold_n   (hold_n)
  );

  psc_switch_decode u_dec (
    .chan  (chan_n),
    .single(single_n),
    .pd    (pd_n),
    .phase (phase_n),
    .hold  (hold_n),
    .csn   (csn),
    .touch (pen_touch),
    .corner(corner_d),
    .sense (sense_d),
    .irq_n (irq_n_d),
    .mux   (mux_d),
    .ovr   (ovr_d),
    .oval  (oval_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      corner_q  <= '0;
      pen_path  <= 1'b0;
      pen_irq_n <= 1'b1;
      mux_sel   <= MUX_NONE;
      dout_ovr  <= 1'b0;
      dout_val  <= 1'b0;
    end else begin
      corner_q  <= corner_d;
      pen_path  <= sense_d;
      pen_irq_n <= irq_n_d;
      mux_sel   <= mux_d;
      dout_ovr  <= ovr_d;
      dout_val  <= oval_d;
    end
  end

  assign drv_ul_sup = corner_q.ul_sup;
  assign drv_ur_sup = corner_q.ur_sup;
  assign drv_ur_gnd = corner_q.ur_gnd;
  assign drv_ll_sup = corner_q.ll_sup;
  assign drv_ll_gnd = corner_q.ll_gnd;
  assign drv_lr_gnd = corner_q.lr_gnd;
endmodule

// File: rtl/psc_checker.sv
module psc_checker
  import psc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             csn,
  input logic             drv_ul_sup,
  input logic             drv_ur_sup,
  input logic             drv_ur_gnd,
  input logic             drv_ll_sup,
  input logic             drv_ll_gnd,
  input logic             drv_lr_gnd,
  input logic             pen_path,
  input logic             pen_irq_n,
  input logic [MUX_W-1:0] mux_sel,
  input logic             dout_ovr,
  input logic             dout_val
);
  p_no_short_r3: assert property (@(posedge clk) disable iff (rst)
    !(drv_ur_sup && drv_ur_gnd) && !(drv_ll_sup && drv_ll_gnd));

  p_aux_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (mux_sel == MUX_AUX) |-> !(drv_ul_sup || drv_ur_sup || drv_ur_gnd ||
                               drv_ll_sup || drv_ll_gnd));

  p_irq_needs_path_r7: assert property (@(posedge clk) disable iff (rst)
    !pen_irq_n |-> (pen_path && drv_lr_gnd));

  p_sense_no_supply_r10: assert property (@(posedge clk) disable iff (rst)
    pen_path |-> !(drv_ul_sup || drv_ur_sup || drv_ll_sup));

  p_cs_kills_ovr_r11: assert property (@(posedge clk) disable iff (rst)
    csn |=> !dout_ovr);

  p_val_needs_ovr_r11: assert property (@(posedge clk) disable iff (rst)
    dout_val |-> dout_ovr);
endmodule

bind panel_switch_ctrl psc_checker i_psc_checker (
  .clk       (clk),
  .rst       (rst),
  .csn       (csn),
  .drv_ul_sup(drv_ul_sup),
  .drv_ur_sup(drv_ur_sup),
  .drv_ur_gnd(drv_ur_gnd),
  .drv_ll_sup(drv_ll_sup),
  .drv_ll_gnd(drv_ll_gnd),
  .drv_lr_gnd(drv_lr_gnd),
  .pen_path  (pen_path),
  .pen_irq_n (pen_irq_n),
  .mux_sel   (mux_sel),
  .dout_ovr  (dout_ovr),
  .dout_val  (dout_val)
);

// File: tb/test_panel_switch_ctrl.sv
`timescale 1ns/1ps
module test_panel_switch_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_valid = 1'b0;
  logic [2:0] cfg_chan = 3'd0;
  logic cfg_single = 1'b1;
  logic [1:0] cfg_pd = 2'd0;
  logic stb_idle = 1'b0, stb_acq = 1'b0, stb_conv = 1'b0, stb_pdn = 1'b0;
  logic csn = 1'b0;
  logic pen_touch = 1'b0;
  logic drv_ul_sup, drv_ur_sup, drv_ur_gnd, drv_ll_sup, drv_ll_gnd, drv_lr_gnd;
  logic pen_path, pen_irq_n, dout_ovr, dout_val;
  logic [1:0] mux_sel;

  always #2 clk = ~clk;

  panel_switch_ctrl i_panel_switch_ctrl (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_chan(cfg_chan),
    .cfg_single(cfg_single), .cfg_pd(cfg_pd), .stb_idle(stb_idle),
    .stb_acq(stb_acq), .stb_conv(stb_conv), .stb_pdn(stb_pdn), .csn(csn),
    .pen_touch(pen_touch), .drv_ul_sup(drv_ul_sup), .drv_ur_sup(drv_ur_sup),
    .drv_ur_gnd(drv_ur_gnd), .drv_ll_sup(drv_ll_sup), .drv_ll_gnd(drv_ll_gnd),
    .drv_lr_gnd(drv_lr_gnd), .pen_path(pen_path), .pen_irq_n(pen_irq_n),
    .mux_sel(mux_sel), .dout_ovr(dout_ovr), .dout_val(dout_val)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_ch, m_pd, m_ph;
  bit m_s, m_hold;
  logic [11:0] exp_v;

  function automatic logic [11:0] model_out();
    bit on, meas, snse;
    logic [11:0] v;
    meas = (m_ch == 1) || (m_ch == 5);
    on = meas && (m_ph == 1 || (m_ph == 2 && !m_s) || m_hold);
    snse = (m_pd == 0) && !on && (m_ph == 0 || m_ph == 3);
    v = '0;
    if (on && m_ch == 1) v[11:6] = 6'b110011;
    if (on && m_ch == 5) v[11:6] = 6'b101101;
    if (snse) begin v[6] = 1'b1; v[5] = 1'b1; end
    v[4] = !(snse && pen_touch);
    v[3:2] = meas ? 2'd1 : (m_ch == 2 ? 2'd2 : 2'd0);
    v[1] = (m_ch == 6) && (m_pd == 0) && !csn;
    v[0] = v[1] && pen_touch;
    return v;
  endfunction

  always @(posedge clk) begin
    bit chg, meas;
    int nph;
    if (rst) begin
      m_ch = 0; m_s = 1; m_pd = 0; m_ph = 0; m_hold = 0;
      exp_v = 12'b000000_0_1_00_0_0;
    end else begin
      chg = cfg_valid && (int'(cfg_chan) != m_ch || cfg_single != m_s ||
                          int'(cfg_pd) != m_pd);
      if (cfg_valid) begin m_ch = cfg_chan; m_s = cfg_single; m_pd = cfg_pd; end
      nph = stb_conv ? 2 : stb_acq ? 1 : stb_pdn ? 3 : stb_idle ? 0 : m_ph;
      meas = (m_ch == 1) || (m_ch == 5);
      if (csn || chg || nph == 1) m_hold = 0;
      else if (m_ph == 2 && nph != 2 && m_pd == 3 && meas) m_hold = 1;
      m_ph = nph;
      exp_v = model_out();
    end
    #1;
    nchk++;
    if ({drv_ul_sup, drv_ur_sup, drv_ur_gnd, drv_ll_sup, drv_ll_gnd, drv_lr_gnd,
         pen_path, pen_irq_n, mux_sel, dout_ovr, dout_val} !== exp_v) begin
      nfail++;
      $display("FAIL %s cycle %0d: got %b expected %b", cur_req, cyc,
               {drv_ul_sup, drv_ur_sup, drv_ur_gnd, drv_ll_sup, drv_ll_gnd,
                drv_lr_gnd, pen_path, pen_irq_n, mux_sel, dout_ovr, dout_val},
               exp_v);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      nfail++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic setcfg(input int ch, input bit s, input int p);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_chan = ch[2:0]; cfg_single = s; cfg_pd = p[1:0];
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic pulse(input bit i, input bit a, input bit c, input bit p);
    @(negedge clk);
    stb_idle = i; stb_acq = a; stb_conv = c; stb_pdn = p;
    @(negedge clk);
    stb_idle = 0; stb_acq = 0; stb_conv = 0; stb_pdn = 0;
  endtask

  task automatic run_conv();
    pulse(0, 1, 0, 0); repeat (2) @(negedge clk);
    pulse(0, 0, 1, 0); repeat (3) @(negedge clk);
    pulse(1, 0, 0, 0); repeat (2) @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R7 pen sensing in idle and power-down with code 00
    cur_req = "R7";
    pen_touch = 1'b1; repeat (2) @(negedge clk);
    pen_touch = 1'b0; @(negedge clk);
    pulse(0, 0, 0, 1); pen_touch = 1'b1; repeat (2) @(negedge clk);
    pen_touch = 1'b0; pulse(1, 0, 0, 0);

    // R2 vertical, single-ended; R5 on-time
    cur_req = "R2_R5"; setcfg(1, 1, 1); run_conv();
    // R3 horizontal, single-ended
    cur_req = "R3_R5"; setcfg(5, 1, 1); run_conv();
    // R6 ratiometric, both channels
    cur_req = "R6"; setcfg(5, 0, 1); run_conv();
    setcfg(1, 0, 2); run_conv();

    // R10 measurement with sense code: pen path detached during measure
    cur_req = "R10"; setcfg(1, 0, 0); pen_touch = 1'b1; run_conv();
    pen_touch = 1'b0;

    // R8 quiet codes ignore touch
    cur_req = "R8"; setcfg(0, 1, 1); pen_touch = 1'b1; repeat (3) @(negedge clk);
    pulse(0, 0, 0, 1); repeat (2) @(negedge clk);
    setcfg(0, 1, 2); repeat (3) @(negedge clk);
    pulse(1, 0, 0, 0); pen_touch = 1'b0;

    // R9 hold with code 11
    cur_req = "R9"; setcfg(1, 1, 3); run_conv();
    repeat (3) @(negedge clk);
    setcfg(1, 1, 3); repeat (2) @(negedge clk);   // identical write keeps hold
    setcfg(1, 0, 3); repeat (2) @(negedge clk);   // changed field releases
    run_conv();
    @(negedge clk); csn = 1'b1; @(negedge clk); csn = 1'b0;
    repeat (2) @(negedge clk);
    setcfg(5, 1, 3); run_conv();
    pulse(0, 1, 0, 0); pulse(0, 0, 1, 0); repeat (2) @(negedge clk);
    pulse(0, 0, 0, 1); repeat (2) @(negedge clk);

    // R4 auxiliary, polling and unused codes
    cur_req = "R4";
    setcfg(2, 0, 3); run_conv();
    setcfg(6, 0, 1); run_conv();
    setcfg(3, 0, 3); run_conv();
    setcfg(7, 1, 3); run_conv();

    // R11 polling override
    cur_req = "R11"; setcfg(6, 1, 0); repeat (2) @(negedge clk);
    pen_touch = 1'b1; repeat (2) @(negedge clk);
    csn = 1'b1; repeat (2) @(negedge clk);
    csn = 1'b0; repeat (2) @(negedge clk);
    setcfg(6, 1, 1); repeat (2) @(negedge clk);
    pen_touch = 1'b0;

    // R12 simultaneous strobes
    cur_req = "R12"; setcfg(1, 1, 0);
    pulse(1, 1, 1, 1); repeat (2) @(negedge clk);
    pulse(1, 1, 0, 1); repeat (2) @(negedge clk);
    pulse(1, 0, 0, 1); repeat (2) @(negedge clk);
    pulse(1, 0, 0, 0); repeat (2) @(negedge clk);
    setcfg(5, 0, 2);
    pulse(0, 1, 1, 0); repeat (2) @(negedge clk);
    pulse(1, 0, 0, 1); repeat (2) @(negedge clk);

    // R1 again: reset mid-operation
    cur_req = "R1"; setcfg(1, 0, 3); pulse(0, 1, 0, 0);
    rst = 1'b1; repeat (2) @(negedge clk);
    rst = 1'b0; repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule